// File: doc/BRIEF.md
# Inbound Message-Signalled Interrupt Receiver

This block sits inside a PCIe root complex, downstream of the transaction-layer decoder. Each cycle it may be handed one inbound posted memory write that has already been decoded into an address, a data word and a valid strobe. Software programs a 64-bit message target address. A write whose full address equals that target is taken as an interrupt message. Its data word is the global vector index.

The vectors are split into groups of 32. Each group holds three registers: an enable, a mask and a write-one-to-clear pending status. Each group drives its own interrupt line. A shared line, the OR of all group lines, serves platforms that wire only one interrupt. Software reaches every register through a simple single-cycle register bus with combinational read data.

Top module: `msi_rx_top`

## Requirements
- R1: After reset, every enable register reads 0, every mask register reads all ones, every status register reads 0, both target-address halves read 0, and all interrupt outputs are low.
- R2: Register map: target address low word at 0x00 and high word at 0x04. Group g has its enable at 0x10+0x10*g, its mask at 0x14+0x10*g and its status at 0x18+0x10*g. Enable, mask and target registers read back what was last written. Unmapped addresses read 0.
- R3: A message is claimed only when all 64 address bits equal the programmed target. A difference in the low word alone, or in the high word alone, leaves every status bit unchanged.
- R4: A claimed vector v sets status bit v mod 32 of group v div 32 and no other bit.
- R5: A status bit is set only when the matching enable bit is 1.
- R6: A data value at or beyond NUM_GRPS*32 is ignored, including values with high-order bits set.
- R7: Writing the status register clears exactly the bits written as 1. Other pending bits are untouched.
- R8: When a message sets a bit in the same cycle that a status write clears that bit, the bit stays set.
- R9: A group interrupt output is high while any bit of (status AND NOT mask) in that group is 1. A mask bit of 1 suppresses that vector's contribution.
- R10: The shared interrupt output equals the OR of all group interrupt outputs.
- R11: A claimed message is visible in status and on the interrupt outputs after the next rising clock edge, not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Write when 1, read when 0 |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on address |
| msg_valid_i | input | 1 | Decoded inbound posted write present |
| msg_addr_i | input | 64 | Inbound write address |
| msg_data_i | input | 32 | Inbound write data (vector index) |
| grp_irq_o | output | NUM_GRPS | Per-group interrupt lines |
| irq_shared_o | output | 1 | OR of all group interrupt lines |

## Verification
A table of inbound writes is replayed. The vectors in it sit at both ends of the first group, at both edges of a group boundary, in the middle of the range and at the last vector. This separates a correct quotient/remainder split from one that is off by one, and a correct range limit from one that stops short. The table also holds writes whose address differs only in the high word or only in the low word, and writes whose data is one past the range or has its top bit set. These show whether the address compare spans all 64 bits and whether the range check sees the whole data word. Directed cases then combine a message and a clear in the same cycle, clear one bit out of two pending, disable a single enable bit, and mask a pending bit and unmask it again, so that the status path and the interrupt path are each judged apart.

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;
  localparam int unsigned REG_DW   = 32;
  localparam int unsigned REG_AW   = 8;
  localparam int unsigned GRP_W    = REG_DW;
  localparam int unsigned BIT_W    = $clog2(GRP_W);
  localparam int unsigned MAX_GRPS = 8;

  localparam logic [REG_AW-1:0] ADR_TGT_LO = 8'h00;
  localparam logic [REG_AW-1:0] ADR_TGT_HI = 8'h04;
  localparam int unsigned       GRP_BASE   = 16;
  localparam int unsigned       GRP_STRIDE = 16;

  typedef enum logic [3:0] {
    FLD_EN  = 4'h0,
    FLD_MSK = 4'h4,
    FLD_STS = 4'h8
  } grp_fld_e;

  function automatic logic [REG_AW-1:0] grp_adr(int unsigned g, grp_fld_e f);
    return REG_AW'(GRP_BASE + g * GRP_STRIDE + int'(f));
  endfunction
endpackage

// File: rtl/msi_rx_regif.sv
module msi_rx_regif
  import msi_rx_pkg::*;
#(
  parameter int unsigned NUM_GRPS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [REG_DW-1:0]   wdata_i,
  output logic [REG_DW-1:0]   rdata_o,
  output logic [63:0]         tgt_o,
  output logic [NUM_GRPS-1:0] en_we_o,
  output logic [NUM_GRPS-1:0] msk_we_o,
  output logic [NUM_GRPS-1:0] sts_we_o,
  input  logic [GRP_W-1:0]    en_rd_i  [NUM_GRPS],
  input  logic [GRP_W-1:0]    msk_rd_i [NUM_GRPS],
  input  logic [GRP_W-1:0]    sts_rd_i [NUM_GRPS]
);
  localparam int unsigned SLOT_LSB = $clog2(GRP_STRIDE);

  logic                wr;
  logic [NUM_GRPS-1:0] gsel;
  logic [31:0]         tgt_lo_q, tgt_hi_q;

  assign wr    = req_i & we_i;
  assign tgt_o = {tgt_hi_q, tgt_lo_q};

  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_dec
    assign gsel[g]     = addr_i >= grp_adr(g, FLD_EN) &&
                         addr_i <  REG_AW'(grp_adr(g, FLD_EN) + GRP_STRIDE);
    assign en_we_o[g]  = wr & gsel[g] & (addr_i[SLOT_LSB-1:0] == FLD_EN);
    assign msk_we_o[g] = wr & gsel[g] & (addr_i[SLOT_LSB-1:0] == FLD_MSK);
    assign sts_we_o[g] = wr & gsel[g] & (addr_i[SLOT_LSB-1:0] == FLD_STS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_lo_q <= '0;
      tgt_hi_q <= '0;
    end else if (wr) begin
      if (addr_i == ADR_TGT_LO) tgt_lo_q <= wdata_i;
      if (addr_i == ADR_TGT_HI) tgt_hi_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADR_TGT_LO) rdata_o = tgt_lo_q;
    if (addr_i == ADR_TGT_HI) rdata_o = tgt_hi_q;
    for (int g = 0; g < NUM_GRPS; g++) begin
      if (gsel[g]) begin
        unique case (addr_i[SLOT_LSB-1:0])
          FLD_EN:  rdata_o = en_rd_i[g];
          FLD_MSK: rdata_o = msk_rd_i[g];
          FLD_STS: rdata_o = sts_rd_i[g];
          default: rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/msi_rx_match.sv
module msi_rx_match
  import msi_rx_pkg::*;
#(
  parameter int unsigned NUM_GRPS = 8
) (
  input  logic                msg_valid_i,
  input  logic [63:0]         msg_addr_i,
  input  logic [31:0]         msg_data_i,
  input  logic [63:0]         tgt_i,
  output logic [NUM_GRPS-1:0] grp_sel_o,
  output logic [GRP_W-1:0]    bit_sel_o
);
  localparam int unsigned NVEC = NUM_GRPS * GRP_W;

  logic            claim;
  logic [31-BIT_W:0] quot;

  assign claim     = msg_valid_i && (msg_addr_i == tgt_i) && (msg_data_i < 32'(NVEC));
  assign quot      = msg_data_i[31:BIT_W];
  assign bit_sel_o = GRP_W'(1) << msg_data_i[BIT_W-1:0];

  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_sel
    assign grp_sel_o[g] = claim && (quot == (32-BIT_W)'(g));
  end
endmodule

// File: rtl/msi_rx_grp.sv
module msi_rx_grp
  import msi_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_we_i,
  input  logic             msk_we_i,
  input  logic             sts_we_i,
  input  logic [GRP_W-1:0] wdata_i,
  input  logic [GRP_W-1:0] set_i,
  output logic [GRP_W-1:0] en_o,
  output logic [GRP_W-1:0] msk_o,
  output logic [GRP_W-1:0] sts_o,
  output logic             irq_o
);
  logic [GRP_W-1:0] clr, sts_d;

  assign clr   = sts_we_i ? wdata_i : '0;
  // set is applied after clear so a same-cycle message survives
  assign sts_d = (sts_o & ~clr) | (set_i & en_o);
  assign irq_o = |(sts_o & ~msk_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= '0;
      msk_o <= '1;
      sts_o <= '0;
    end else begin
      if (en_we_i)  en_o  <= wdata_i;
      if (msk_we_i) msk_o <= wdata_i;
      sts_o <= sts_d;
    end
  end
endmodule

// File: rtl/msi_rx_top.sv
module msi_rx_top
  import msi_rx_pkg::*;
#(
  parameter int unsigned NUM_GRPS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_req_i,
  input  logic                reg_we_i,
  input  logic [7:0]          reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  input  logic                msg_valid_i,
  input  logic [63:0]         msg_addr_i,
  input  logic [31:0]         msg_data_i,
  output logic [NUM_GRPS-1:0] grp_irq_o,
  output logic                irq_shared_o
);
  logic [63:0]         tgt;
  logic [NUM_GRPS-1:0] en_we, msk_we, sts_we, grp_sel;
  logic [GRP_W-1:0]    bit_sel;
  logic [GRP_W-1:0]    en_r  [NUM_GRPS];
  logic [GRP_W-1:0]    msk_r [NUM_GRPS];
  logic [GRP_W-1:0]    sts_r [NUM_GRPS];
  logic [NUM_GRPS*GRP_W-1:0] sts_all;

  msi_rx_regif #(.NUM_GRPS(NUM_GRPS)) u_regif (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (reg_req_i),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .tgt_o    (tgt),
    .en_we_o  (en_we),
    .msk_we_o (msk_we),
    .sts_we_o (sts_we),
    .en_rd_i  (en_r),
    .msk_rd_i (msk_r),
    .sts_rd_i (sts_r)
  );

  msi_rx_match #(.NUM_GRPS(NUM_GRPS)) u_match (
    .msg_valid_i (msg_valid_i),
    .msg_addr_i  (msg_addr_i),
    .msg_data_i  (msg_data_i),
    .tgt_i       (tgt),
    .grp_sel_o   (grp_sel),
    .bit_sel_o   (bit_sel)
  );

  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
    msi_rx_grp u_grp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_we_i  (en_we[g]),
      .msk_we_i (msk_we[g]),
      .sts_we_i (sts_we[g]),
      .wdata_i  (reg_wdata_i),
      .set_i    (grp_sel[g] ? bit_sel : '0),
      .en_o     (en_r[g]),
      .msk_o    (msk_r[g]),
      .sts_o    (sts_r[g]),
      .irq_o    (grp_irq_o[g])
    );
    assign sts_all[g*GRP_W +: GRP_W] = sts_r[g];
  end

  assign irq_shared_o = |grp_irq_o;
endmodule

// File: rtl/msi_rx_chk.sv
module msi_rx_chk
  import msi_rx_pkg::*;
#(
  parameter int unsigned NUM_GRPS = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      reg_req_i,
  input logic                      reg_we_i,
  input logic [7:0]                reg_addr_i,
  input logic [31:0]               reg_wdata_i,
  input logic                      msg_valid_i,
  input logic [31:0]               msg_data_i,
  input logic [NUM_GRPS-1:0]       grp_irq_o,
  input logic                      irq_shared_o,
  input logic [NUM_GRPS*GRP_W-1:0] sts_all_i
);
  localparam int unsigned NVEC = NUM_GRPS * GRP_W;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (grp_irq_o == '0 && sts_all_i == '0);
    end
  end

  assert_shared_or_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_shared_o == (|grp_irq_o));

  assert_irq_needs_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!msg_valid_i && !(reg_req_i && reg_we_i)) |=> ((grp_irq_o & ~$past(grp_irq_o)) == '0));

  assert_oob_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && msg_data_i >= 32'(NVEC) && !(reg_req_i && reg_we_i)) |=> $stable(sts_all_i));

  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_w1c
    assert_w1c_exact_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_req_i && reg_we_i && reg_addr_i == grp_adr(g, FLD_STS) && !msg_valid_i)
      |=> sts_all_i[g*GRP_W +: GRP_W] ==
          ($past(sts_all_i[g*GRP_W +: GRP_W]) & ~$past(reg_wdata_i)));
  end
endmodule

bind msi_rx_top msi_rx_chk #(.NUM_GRPS(NUM_GRPS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_req_i    (reg_req_i),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .msg_valid_i  (msg_valid_i),
  .msg_data_i   (msg_data_i),
  .grp_irq_o    (grp_irq_o),
  .irq_shared_o (irq_shared_o),
  .sts_all_i    (sts_all)
);

// File: tb/msi_rx_top_test.sv
`timescale 1ns/1ps
module msi_rx_top_test;
  localparam int NG = 8;
  localparam logic [63:0] TGT = 64'h0000_0012_ABCD_0040;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
    logic        claim;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{TGT, 32'd0, 1'b1},
    '{TGT, 32'd31, 1'b1},
    '{TGT, 32'd32, 1'b1},
    '{TGT, 32'd63, 1'b1},
    '{TGT, 32'd100, 1'b1},
    '{TGT, 32'd255, 1'b1},
    '{TGT, 32'd256, 1'b0},
    '{TGT, 32'h8000_0003, 1'b0},
    '{TGT ^ 64'h1_0000_0000, 32'd5, 1'b0},
    '{TGT ^ 64'h4, 32'd7, 1'b0}
  };

  logic        clk = 0, rst_n = 1;
  logic        reg_req = 0, reg_we = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        msg_valid = 0;
  logic [63:0] msg_addr = 0;
  logic [31:0] msg_data = 0;
  logic [NG-1:0] grp_irq;
  logic        irq_sh;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  msi_rx_top #(.NUM_GRPS(NG)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .msg_valid_i(msg_valid), .msg_addr_i(msg_addr), .msg_data_i(msg_data),
    .grp_irq_o(grp_irq), .irq_shared_o(irq_sh)
  );

  function automatic logic [7:0] a_en(int g);  return 8'(16 + 16*g);     endfunction
  function automatic logic [7:0] a_msk(int g); return 8'(16 + 16*g + 4); endfunction
  function automatic logic [7:0] a_sts(int g); return 8'(16 + 16*g + 8); endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; reg_req = 1; reg_we = 0;
    #0.5;
    d = reg_rdata;
    reg_req = 0;
  endtask

  task automatic send(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk);
    msg_valid = 1; msg_addr = a; msg_data = d;
    @(negedge clk);
    msg_valid = 0;
  endtask

  task automatic clear_all();
    for (int g = 0; g < NG; g++) reg_wr(a_sts(g), 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [NG*32-1:0] sts_seen, sts_exp;
    logic [NG-1:0] irq_exp;
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 irq", {grp_irq, irq_sh}, '0);
    for (int g = 0; g < NG; g++) begin
      reg_rd(a_en(g), rd);  chk("R1 enable", rd, 32'h0);
      reg_rd(a_msk(g), rd); chk("R1 mask", rd, 32'hFFFF_FFFF);
      reg_rd(a_sts(g), rd); chk("R1 status", rd, 32'h0);
    end
    reg_rd(8'h00, rd); chk("R1 tgt lo", rd, 32'h0);
    rst_n = 1;
    @(negedge clk);

    // R2: target and map readback
    reg_wr(8'h00, TGT[31:0]);
    reg_wr(8'h04, TGT[63:32]);
    reg_rd(8'h00, rd); chk("R2 tgt lo", rd, TGT[31:0]);
    reg_rd(8'h04, rd); chk("R2 tgt hi", rd, TGT[63:32]);
    reg_rd(8'h0C, rd); chk("R2 unmapped", rd, 32'h0);
    for (int g = 0; g < NG; g++) begin
      reg_wr(a_en(g), 32'hFFFF_FFFF);
      reg_wr(a_msk(g), 32'h0);
    end
    reg_rd(a_msk(5), rd); chk("R2 mask rb", rd, 32'h0);
    reg_rd(a_en(7), rd);  chk("R2 enable rb", rd, 32'hFFFF_FFFF);

    // R3 R4 R6: table walk
    foreach (VECS[i]) begin
      send(VECS[i].addr, VECS[i].data);
      sts_exp = '0;
      irq_exp = '0;
      if (VECS[i].claim) begin
        sts_exp[VECS[i].data] = 1'b1;
        irq_exp[VECS[i].data / 32] = 1'b1;
      end
      for (int g = 0; g < NG; g++) begin
        reg_rd(a_sts(g), rd);
        sts_seen[g*32 +: 32] = rd;
      end
      chk(VECS[i].claim ? "R4 status" : "R3/R6 status", sts_seen, sts_exp);
      chk("R9 irq", {56'h0, grp_irq}, {56'h0, irq_exp});
      chk("R10 shared", irq_sh, |irq_exp);
      clear_all();
    end

    // R11: not visible before the edge, visible after
    @(negedge clk);
    msg_valid = 1; msg_addr = TGT; msg_data = 32'd70;
    #1 chk("R11 before edge", grp_irq, '0);
    @(negedge clk);
    msg_valid = 0;
    chk("R11 after edge", grp_irq, NG'(1 << 2));
    clear_all();

    // R7: clear one of two pending bits
    send(TGT, 32'd67);
    send(TGT, 32'd69);
    reg_wr(a_sts(2), 32'h0000_0008);
    reg_rd(a_sts(2), rd); chk("R7 partial clear", rd, 32'h0000_0020);
    chk("R7 irq kept", grp_irq[2], 1'b1);
    clear_all();

    // R8: same-cycle set and clear
    send(TGT, 32'd40);
    @(negedge clk);
    msg_valid = 1; msg_addr = TGT; msg_data = 32'd40;
    reg_req = 1; reg_we = 1; reg_addr = a_sts(1); reg_wdata = 32'h0000_0100;
    @(negedge clk);
    msg_valid = 0; reg_req = 0; reg_we = 0;
    reg_rd(a_sts(1), rd); chk("R8 set wins", rd, 32'h0000_0100);
    reg_wr(a_sts(1), 32'h0000_0100);
    reg_rd(a_sts(1), rd); chk("R8 then clears", rd, 32'h0);

    // R5: disabled bit not latched
    reg_wr(a_en(1), ~32'h0000_0200);
    send(TGT, 32'd41);
    reg_rd(a_sts(1), rd); chk("R5 disabled", rd, 32'h0);
    chk("R5 irq", grp_irq[1], 1'b0);
    send(TGT, 32'd42);
    reg_rd(a_sts(1), rd); chk("R5 neighbour enabled", rd, 32'h0000_0400);
    clear_all();
    reg_wr(a_en(1), 32'hFFFF_FFFF);

    // R9 R10: masking
    reg_wr(a_msk(3), 32'h0000_0004);
    send(TGT, 32'd98);
    reg_rd(a_sts(3), rd); chk("R9 masked status", rd, 32'h0000_0004);
    chk("R9 masked irq", grp_irq[3], 1'b0);
    chk("R10 masked shared", irq_sh, 1'b0);
    reg_wr(a_msk(3), 32'h0);
    chk("R9 unmasked irq", grp_irq[3], 1'b1);
    chk("R10 unmasked shared", irq_sh, 1'b1);
    clear_all();
    chk("R7 all cleared", {grp_irq, irq_sh}, '0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule